// File: doc/BRIEF.md
# Output compare unit

This block watches a free-running timer count supplied from outside and compares it against five 16-bit compare values. Each channel has one enable bit in a mask byte and one flag bit in a flag byte. When the counter advances (signalled by a one-cycle strobe that comes with the new count value) and an enabled channel's compare value equals that count, the channel's flag is set. The flags are cleared by writing ones to them. A single interrupt request is raised while any flag is set on a channel that is also enabled.

Software reaches the block through a byte-wide register port. There are ten compare bytes, a mask byte and a flag byte. Writes take effect at the next clock edge and reads are combinational. The count, the counter itself and any prescaling stay outside this block. A compare is evaluated only on a counter advance. So writing a compare value or an enable that happens to equal the count already present never raises a flag at once. The flag waits until the counter comes back around to that value.

Top module: `oc_compare_unit`

## Requirements
- R1: Channel k (k = 0..4) has a 16-bit compare value with its upper byte at address 2k and its lower byte at address 2k+1. Each byte is written and read independently, and a write to one byte leaves the other byte unchanged.
- R2: The enable byte sits at address 10 and the flag byte at address 11. Channel k uses bit 7-k in both, so channel 0 is bit 7 and channel 4 is bit 3. Bits 2..0 always read 0, and writes to them are ignored.
- R3: In a cycle where cnt_tick is high, an enabled channel whose compare value equals cnt_value has its flag set at that clock edge.
- R4: A flag is never set in a cycle without cnt_tick. Writing a compare value or an enable that equals the count already present sets nothing, and a flag cleared while the count stays the same is not set again.
- R5: A channel whose enable bit is 0 never has its flag set, even when its compare value matches the count on a tick.
- R6: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: When a tick sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R8: irq is high exactly when some channel has both its flag and its enable set. Clearing an enable lowers irq but keeps the flag.
- R9: After reset all flags and enables are 0, every compare value is 0xFFFF, and irq is low.
- R10: Addresses 12 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | One-cycle strobe: the count has just advanced |
| cnt_value | input | 16 | Current timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq | output | 1 | Combined compare interrupt request |

## Verification
The failures that matter are internal state that is wrong but stays hidden: a compare byte written into the wrong half, a flag set from a stale count, or an enable gating the wrong bit. Every such fault shows up in rd_data on the cycle after the write or tick that caused it. A flag that is missing or set when it should not be also shows up on irq in that same cycle, as long as its channel is enabled. The bench reads back every address after each stimulus cycle, so a divergence is reported within one clock. Random traffic with a narrow range of counts makes matches, collisions with clears, and writes at the present count happen often.

// File: rtl/oc_pkg.sv
package oc_pkg;
   // Bit position of a channel inside the enable and flag bytes.
   function automatic int unsigned oc_bit_pos(input int unsigned ch, input int unsigned dw);
      return dw - 1 - ch;
   endfunction

   // Address of the enable byte, directly after the compare bytes.
   function automatic int unsigned oc_mask_addr(input int unsigned nch);
      return 2 * nch;
   endfunction

   // Address of the flag byte.
   function automatic int unsigned oc_flag_addr(input int unsigned nch);
      return 2 * nch + 1;
   endfunction
endpackage

// File: rtl/oc_channel.sv
module oc_channel #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DATA_W   = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   input  logic [CNT_W-1:0]  count,
   input  logic              enable,
   input  logic              clr,
   output logic [CNT_W-1:0]  cmp_value,
   output logic              flag
);
   localparam int unsigned HI_LSB = CNT_W - DATA_W;

   logic [CNT_W-1:0] cmp_q;
   logic             flag_q;
   logic             flag_d;
   logic             hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
      end else begin
         if (wr_hi) cmp_q[CNT_W-1:HI_LSB] <= wr_data;
         if (wr_lo) cmp_q[DATA_W-1:0]     <= wr_data;
      end
   end

   // Evaluation happens only on a counter advance.
   assign hit = tick && enable && (cmp_q == count);

   generate
      if (SET_WINS) begin : g_set_first
         assign flag_d = hit || (flag_q && !clr);
      end else begin : g_clr_first
         assign flag_d = (hit || flag_q) && !clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign cmp_value = cmp_q;
   assign flag      = flag_q;

   AST_CMP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hi && !wr_lo) |=> $stable(cmp_q)); // R1
   AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick && enable && (cmp_q == count))); // R3
   AST_NO_SET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !flag_q) |=> !flag_q); // R4
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !flag_q) |=> !flag_q); // R5
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !flag_q); // R6
   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q); // R6
   generate
      if (SET_WINS) begin : g_chk_set
         AST_SET_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> flag_q); // R7
      end
   endgenerate
endmodule

// File: rtl/oc_read_mux.sv
module oc_read_mux
   import oc_pkg::*;
#(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [NUM_CH*CNT_W-1:0] cmp_flat,
   input  logic [DATA_W-1:0]       mask_byte,
   input  logic [DATA_W-1:0]       flag_byte,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_data
);
   localparam int unsigned MASK_A = oc_mask_addr(NUM_CH);
   localparam int unsigned FLAG_A = oc_flag_addr(NUM_CH);

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (rd_addr == ADDR_W'(2 * k))
            rd_data = cmp_flat[k*CNT_W + DATA_W +: DATA_W];
         if (rd_addr == ADDR_W'(2 * k + 1))
            rd_data = cmp_flat[k*CNT_W +: DATA_W];
      end
      if (rd_addr == ADDR_W'(MASK_A)) rd_data = mask_byte;
      if (rd_addr == ADDR_W'(FLAG_A)) rd_data = flag_byte;
   end
endmodule

// File: rtl/oc_compare_unit.sv
module oc_compare_unit
   import oc_pkg::*;
#(
   parameter int unsigned NUM_CH   = 5,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int unsigned MASK_A = oc_mask_addr(NUM_CH);
   localparam int unsigned FLAG_A = oc_flag_addr(NUM_CH);

   generate
      if (NUM_CH > DATA_W) begin : g_bad_ch
         $error("NUM_CH must fit in one register byte");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_w
         $error("CNT_W must be two register bytes wide");
      end
      if ((1 << ADDR_W) < FLAG_A + 1) begin : g_bad_a
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic                    wr_mask;
   logic                    wr_flag;
   logic [NUM_CH-1:0]       en_q;
   logic [NUM_CH-1:0]       flag_v;
   logic [NUM_CH-1:0]       clr_v;
   logic [NUM_CH*CNT_W-1:0] cmp_flat;
   logic [DATA_W-1:0]       mask_byte;
   logic [DATA_W-1:0]       flag_byte;

   assign wr_mask = wr_en && (wr_addr == ADDR_W'(MASK_A));
   assign wr_flag = wr_en && (wr_addr == ADDR_W'(FLAG_A));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_mask) begin
         for (int k = 0; k < NUM_CH; k++)
            en_q[k] <= wr_data[oc_bit_pos(k, DATA_W)];
      end
   end

   genvar gk;
   generate
      for (gk = 0; gk < NUM_CH; gk++) begin : g_ch
         logic wr_hi;
         logic wr_lo;
         assign wr_hi     = wr_en && (wr_addr == ADDR_W'(2 * gk));
         assign wr_lo     = wr_en && (wr_addr == ADDR_W'(2 * gk + 1));
         assign clr_v[gk] = wr_flag && wr_data[DATA_W-1-gk];

         oc_channel #(
            .CNT_W   (CNT_W),
            .DATA_W  (DATA_W),
            .SET_WINS(SET_WINS)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hi    (wr_hi),
            .wr_lo    (wr_lo),
            .wr_data  (wr_data),
            .tick     (cnt_tick),
            .count    (cnt_value),
            .enable   (en_q[gk]),
            .clr      (clr_v[gk]),
            .cmp_value(cmp_flat[gk*CNT_W +: CNT_W]),
            .flag     (flag_v[gk])
         );
      end
   endgenerate

   always_comb begin
      mask_byte = '0;
      flag_byte = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         mask_byte[oc_bit_pos(k, DATA_W)] = en_q[k];
         flag_byte[oc_bit_pos(k, DATA_W)] = flag_v[k];
      end
   end

   oc_read_mux #(
      .NUM_CH(NUM_CH),
      .CNT_W (CNT_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_rd (
      .cmp_flat (cmp_flat),
      .mask_byte(mask_byte),
      .flag_byte(flag_byte),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   assign irq = |(flag_v & en_q);

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(en_q)); // R2
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_q != '0)); // R8
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_v != '0)); // R8
endmodule

// File: tb/oc_compare_unit_tb.sv
module oc_compare_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic [15:0] cnt_value = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   logic [15:0] m_cmp [5];
   logic [7:0]  m_mask;
   logic [7:0]  m_flag;

   always #10 clk = ~clk;

   oc_compare_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_value(cnt_value),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [7:0] exp_rd(input int a);
      if (a < 10) return (a % 2 == 0) ? m_cmp[a/2][15:8] : m_cmp[a/2][7:0];
      if (a == 10) return m_mask;
      if (a == 11) return m_flag;
      return 8'h00;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      rd_addr = 4'(a);
      #1;
      v = rd_data;
   endtask

   // Read every address and irq, compare with the model, realign to negedge.
   task automatic check_all(input string tag);
      logic [7:0] v;
      for (int a = 0; a < 16; a++) begin
         rd(a, v);
         if (a < 10)       chk({tag, " R1 compare byte"}, 16'(v), 16'(exp_rd(a)));
         else if (a < 12)  chk({tag, " R2 enable/flag byte"}, 16'(v), 16'(exp_rd(a)));
         else              chk({tag, " R10 unmapped"}, 16'(v), 16'(exp_rd(a)));
      end
      chk({tag, " R8 irq"}, 16'(irq), 16'(|(m_flag & m_mask)));
      @(negedge clk);
   endtask

   // One clock of stimulus, with the model advanced by the same rules.
   task automatic cyc(input bit we, input int a, input logic [7:0] d,
                      input bit tk, input logic [15:0] cv);
      logic [7:0] nflag;
      wr_en = we; wr_addr = 4'(a); wr_data = d; cnt_tick = tk; cnt_value = cv;
      @(negedge clk);
      nflag = m_flag;
      for (int k = 0; k < 5; k++) begin
         bit set_k;
         bit clr_k;
         set_k = tk && m_mask[7-k] && (m_cmp[k] == cv);
         clr_k = we && (a == 11) && d[7-k];
         nflag[7-k] = set_k || (m_flag[7-k] && !clr_k);
      end
      if (we && a < 10) begin
         if (a % 2 == 0) m_cmp[a/2][15:8] = d;
         else            m_cmp[a/2][7:0]  = d;
      end
      if (we && a == 10) m_mask = d & 8'hF8;
      m_flag = nflag;
      wr_en = 1'b0; cnt_tick = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd1234));
      for (int k = 0; k < 5; k++) m_cmp[k] = 16'hFFFF;
      m_mask = 8'h00; m_flag = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      for (int a = 0; a < 10; a++) begin rd(a, v); chk("R9 compare reset", 16'(v), 16'hFF); end
      rd(10, v); chk("R9 enable reset", 16'(v), 16'h00);
      rd(11, v); chk("R9 flag reset", 16'(v), 16'h00);
      chk("R9 irq reset", 16'(irq), 16'h0);
      @(negedge clk);

      // R1 independent byte writes
      cyc(1, 0, 8'h12, 0, 16'h0000);
      cyc(1, 1, 8'h34, 0, 16'h0000);
      cyc(1, 5, 8'h56, 0, 16'h0000);
      check_all("byte writes");
      rd(4, v); chk("R1 untouched upper byte", 16'(v), 16'hFF);
      @(negedge clk);

      // R3 enabled match on tick, R8 irq
      cyc(1, 10, 8'h80, 0, 16'h1233);
      cyc(0, 0, 8'h00, 1, 16'h1234);
      rd(11, v); chk("R3 flag set on match", 16'(v), 16'h80);
      chk("R8 irq on flag", 16'(irq), 16'h1);
      @(negedge clk);

      // R6 zero write keeps, one write clears; R4 no re-set while count holds
      cyc(1, 11, 8'h00, 0, 16'h1234);
      rd(11, v); chk("R6 zero write keeps flag", 16'(v), 16'h80);
      @(negedge clk);
      cyc(1, 11, 8'h80, 0, 16'h1234);
      cyc(0, 0, 8'h00, 0, 16'h1234);
      cyc(0, 0, 8'h00, 0, 16'h1234);
      rd(11, v); chk("R4 R6 cleared and not re-set", 16'(v), 16'h00);
      @(negedge clk);

      // R5 disabled channel ignores match
      cyc(1, 2, 8'h01, 0, 16'h00FF);
      cyc(1, 3, 8'h00, 0, 16'h00FF);
      cyc(0, 0, 8'h00, 1, 16'h0100);
      rd(11, v); chk("R5 disabled channel no flag", 16'(v), 16'h00);
      chk("R5 irq stays low", 16'(irq), 16'h0);
      @(negedge clk);

      // R4 enable written while count already equals compare
      cyc(1, 10, 8'hC0, 0, 16'h0100);
      cyc(0, 0, 8'h00, 0, 16'h0100);
      rd(11, v); chk("R4 enable at present count sets nothing", 16'(v), 16'h00);
      @(negedge clk);
      // R4 compare written equal to present count
      cyc(1, 9, 8'h77, 0, 16'h0077);
      cyc(1, 8, 8'h00, 0, 16'h0077);
      cyc(1, 10, 8'hC8, 0, 16'h0077);
      rd(11, v); chk("R4 compare at present count sets nothing", 16'(v), 16'h00);
      @(negedge clk);
      cyc(0, 0, 8'h00, 1, 16'h0077);
      rd(11, v); chk("R3 channel 4 bit 3", 16'(v), 16'h08);
      @(negedge clk);

      // R7 set and clear in the same cycle
      cyc(1, 11, 8'h40, 1, 16'h0100);
      rd(11, v); chk("R7 set wins over clear", 16'(v), 16'h48);
      @(negedge clk);

      // R8 disable keeps flag, drops irq
      cyc(1, 10, 8'h00, 0, 16'h0100);
      rd(11, v); chk("R8 flag kept after disable", 16'(v), 16'h48);
      chk("R8 irq low when disabled", 16'(irq), 16'h0);
      @(negedge clk);

      // R2 low bits ignored, R10 unmapped write harmless
      cyc(1, 10, 8'h07, 0, 16'h0100);
      cyc(1, 11, 8'h07, 0, 16'h0100);
      cyc(1, 13, 8'hAA, 0, 16'h0100);
      check_all("low bits and unmapped");

      // Random traffic with a narrow count range
      for (int i = 0; i < 400; i++) begin
         int a;
         logic [7:0] d;
         bit we;
         bit tk;
         logic [15:0] cv;
         we = ($urandom % 2) == 1;
         a  = int'($urandom % 14);
         d  = 8'($urandom);
         if (a < 10 && a % 2 == 0) d = (($urandom % 4) == 0) ? d : 8'h00;
         if (a < 10 && a % 2 == 1) d = 8'h10 + 8'($urandom % 3);
         tk = ($urandom % 3) != 0;
         cv = 16'h0010 + 16'($urandom % 4);
         cyc(we, a, d, tk, cv);
         check_all("random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule